// File: doc/BRIEF.md
# Display Memory Write Command Decoder

This block sits behind a serial byte receiver and turns the received byte stream into write operations on a two-plane on-screen display memory. One plane holds character codes, which are nine bits wide. The other plane holds attribute bytes. Each byte is classified from its header bits. A set bit 7 marks a row byte, and a row byte also selects the plane. A clear bit 7, arriving after a row, marks a column byte. A column byte can carry the ninth data bit and can switch the decoder into streaming mode. All other bytes are payload.

Three packet shapes are supported:
- Single write: row, column, data, repeated.
- Same-row write: one row byte, then column/data pairs.
- Streaming write: row, column, then any number of data bytes, with the address advancing after each byte.

Once streaming has begun, only the end of the transaction leaves it. A start or stop indication from the serial front end returns the decoder to its waiting state.

Top module: `osd_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `wr_en` is low and the decoder waits for a row byte.
- R2: A byte with bit 7 = 1 is a row byte. Bits 4..0 give the row. Bit 5 = 1 selects the attribute plane and bit 5 = 0 selects the character-code plane.
- R3: After a row byte, a byte with bit 7 = 0 is a column byte. Bits 4..0 give the column. Bit 6 = 1 enters streaming mode and bit 6 = 0 expects exactly one data byte.
- R4: In the character-code plane, bit 5 of the column byte becomes `wr_data[8]`, and the data byte supplies `wr_data[7:0]`.
- R5: In the attribute plane, `wr_data[8]` is always 0, whatever the value of bit 5 in the column byte.
- R6: Outside streaming mode, exactly one byte follows each column byte and is taken as data, even when its bit 7 is set. The byte after that data byte is a row byte if bit 7 = 1, or a new column byte for the same row if bit 7 = 0.
- R7: In streaming mode, every byte is written to the current address. The column then increments, and column 31 wraps to 0 while the row increments.
- R8: In streaming mode, the ninth data bit latched from the column byte applies to every following data byte.
- R9: Streaming mode is never left within a transaction. A byte with bit 7 set is still written as data.
- R10: A start/stop pulse (`frame_evt`) returns the decoder to the waiting state. In that state, bytes with bit 7 = 0 are ignored and produce no write.
- R11: Each data byte accepted in cycle n produces a one-cycle `wr_en` pulse in cycle n+1. The row, column, plane and data are registered and presented alongside the pulse.
- R12: A byte presented in the same cycle as `frame_evt` is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_evt | input | 1 | Transaction start or stop pulse from the serial front end |
| byte_vld | input | 1 | `byte_in` holds a received byte this cycle |
| byte_in | input | 8 | Received byte |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_row | output | 5 | Write row |
| wr_col | output | 5 | Write column |
| wr_attr | output | 1 | 1 = attribute plane, 0 = character-code plane |
| wr_data | output | 9 | Write data; bit 8 is meaningful only in the character-code plane |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:

- **Data byte with bit 7 set.** A data byte in single-write or streaming mode has its top bit set. A decoder that classified it as a row byte would drop the write and then misplace the following writes.
- **Streaming across the column boundary.** The bench streams from column 30 and from row 31, column 31. This exposes a missing wrap, a row that fails to advance, and a ninth bit that is lost after the first byte.
- **Plane switch with column bit 5 set.** The bench moves to the attribute plane while column bit 5 is set. A design that leaked this bit into the attribute data would output `wr_data[8]` = 1.
- **Start/stop pulses.** Pulses arrive in the middle of a packet and in the same cycle as a row byte. A decoder that kept its state, or that accepted the colliding byte, would issue writes the scoreboard does not expect.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  localparam int HDR_FIELD_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HDR    = 2'd1,
    ST_DATA1  = 2'd2,
    ST_STREAM = 2'd3
  } dec_state_t;

  typedef struct packed {
    logic                   is_row;
    logic                   stream;
    logic                   sel5;
    logic [HDR_FIELD_W-1:0] addr;
  } hdr_t;

endpackage

// File: rtl/osd_hdr_split.sv
module osd_hdr_split
  import osd_cmd_pkg::*;
(
  input  logic [7:0] byte_i,
  output hdr_t       hdr_o
);

  always_comb begin
    hdr_o.is_row = byte_i[7];
    hdr_o.stream = byte_i[6];
    hdr_o.sel5   = byte_i[5];
    hdr_o.addr   = byte_i[HDR_FIELD_W-1:0];
  end

endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_evt,
  input  logic       byte_vld,
  input  hdr_t       hdr,
  output logic       ld_row,
  output logic       ld_col,
  output logic       wr_req,
  output logic       inc_req,
  output dec_state_t state_o
);

  dec_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    ld_row  = 1'b0;
    ld_col  = 1'b0;
    wr_req  = 1'b0;
    inc_req = 1'b0;
    if (frame_evt) begin
      state_d = ST_IDLE;
    end else if (byte_vld) begin
      case (state_q)
        ST_IDLE: begin
          if (hdr.is_row) begin
            ld_row  = 1'b1;
            state_d = ST_HDR;
          end
        end
        ST_HDR: begin
          if (hdr.is_row) begin
            ld_row  = 1'b1;
          end else begin
            ld_col  = 1'b1;
            state_d = hdr.stream ? ST_STREAM : ST_DATA1;
          end
        end
        ST_DATA1: begin
          wr_req  = 1'b1;
          state_d = ST_HDR;
        end
        default: begin
          wr_req  = 1'b1;
          inc_req = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  a_r9_stream_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STREAM && !frame_evt) |=> (state_q == ST_STREAM));

  a_r10_frame_to_idle: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> (state_q == ST_IDLE));

  a_r10_idle_ignores_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && byte_vld && !hdr.is_row && !frame_evt) |=> (state_q == ST_IDLE));

  a_r6_one_data_byte: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA1 && byte_vld && !frame_evt) |=> (state_q == ST_HDR));

endmodule

// File: rtl/osd_addr_reg.sv
module osd_addr_reg
  import osd_cmd_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int ROW_W    = 5,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_row,
  input  logic             ld_col,
  input  logic             inc,
  input  hdr_t             hdr,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             attr_q,
  output logic             hi_q
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      attr_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (ld_row) begin
      row_q  <= hdr.addr[ROW_W-1:0];
      attr_q <= hdr.sel5;
    end else if (ld_col) begin
      col_q  <= hdr.addr[COL_W-1:0];
      hi_q   <= hdr.sel5 & ~attr_q;
    end else if (inc) begin
      if (col_q == LAST_COL) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  a_r7_col_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_row && !ld_col && col_q != LAST_COL) |=>
      (col_q == $past(col_q) + 1'b1 && row_q == $past(row_q)));

  a_r7_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_row && !ld_col && col_q == LAST_COL) |=>
      (col_q == '0 && row_q == $past(row_q) + 1'b1));

  a_r8_hi_held: assert property (@(posedge clk) disable iff (rst)
    (!ld_col) |=> $stable(hi_q));

endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int ROW_W    = 5,
  parameter int BYTE_W   = 8,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int DATA_W  = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_evt,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_attr,
  output logic [DATA_W-1:0] wr_data
);

  hdr_t             hdr;
  logic             ld_row, ld_col, wr_req, inc_req;
  dec_state_t       state;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             attr_q, hi_q;

  osd_hdr_split u_split (
    .byte_i (byte_in),
    .hdr_o  (hdr)
  );

  osd_cmd_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .frame_evt (frame_evt),
    .byte_vld  (byte_vld),
    .hdr       (hdr),
    .ld_row    (ld_row),
    .ld_col    (ld_col),
    .wr_req    (wr_req),
    .inc_req   (inc_req),
    .state_o   (state)
  );

  osd_addr_reg #(
    .NUM_COLS (NUM_COLS),
    .ROW_W    (ROW_W)
  ) u_addr (
    .clk    (clk),
    .rst    (rst),
    .ld_row (ld_row),
    .ld_col (ld_col),
    .inc    (inc_req),
    .hdr    (hdr),
    .row_q  (row_q),
    .col_q  (col_q),
    .attr_q (attr_q),
    .hi_q   (hi_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_attr <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= wr_req;
      if (wr_req) begin
        wr_row  <= row_q;
        wr_col  <= col_q;
        wr_attr <= attr_q;
        wr_data <= {hi_q, byte_in};
      end
    end
  end

  a_r11_write_after_byte: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(byte_vld) && !$past(frame_evt)));

  a_r5_attr_bit8_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_attr) |-> !wr_data[BYTE_W]);

  a_r1_no_write_in_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !wr_en);

  a_r12_frame_drops_byte: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> !wr_en);

endmodule

// File: tb/osd_cmd_decoder_tb.sv
module osd_cmd_decoder_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_evt;
  logic       byte_vld;
  logic [7:0] byte_in;
  logic       wr_en;
  logic [4:0] wr_row;
  logic [4:0] wr_col;
  logic       wr_attr;
  logic [8:0] wr_data;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  osd_cmd_decoder u_dut (
    .clk       (clk),
    .rst       (rst),
    .frame_evt (frame_evt),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_attr   (wr_attr),
    .wr_data   (wr_data)
  );

  task automatic push_exp(input logic [4:0] r, input logic [4:0] c,
                          input logic a, input logic [8:0] d, input string tag);
    exp_q.push_back({r, c, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic pulse_frame(input logic with_byte, input logic [7:0] b);
    @(negedge clk);
    frame_evt = 1'b1;
    byte_vld  = with_byte;
    byte_in   = b;
    @(negedge clk);
    frame_evt = 1'b0;
    byte_vld  = 1'b0;
  endtask

  task automatic drained(input string tag);
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s: pending writes actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10: unexpected write actual=%h expected=none",
                 {wr_row, wr_col, wr_attr, wr_data});
      end else begin
        logic [19:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({wr_row, wr_col, wr_attr, wr_data} !== e) begin
          bad++;
          $display("FAIL %s: write actual=r%0d c%0d a%0d d%h expected=r%0d c%0d a%0d d%h",
                   t, wr_row, wr_col, wr_attr, wr_data, e[19:15], e[14:10], e[9], e[8:0]);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; frame_evt = 1'b0; byte_vld = 1'b0; byte_in = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (wr_en !== 1'b0) begin
      bad++;
      $display("FAIL R1: wr_en in reset actual=%b expected=0", wr_en);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 / R10: column and data bytes before any row are ignored
    send(8'h05);
    send(8'h33);
    drained("R1");

    // R2 R3 R4: single write in the character-code plane, row 3 col 10, bit8 from col bit5
    push_exp(5'd3, 5'd10, 1'b0, 9'h15C, "R4");
    send(8'h83); send(8'h2A); send(8'h5C);
    // R11: pulse lasts exactly one cycle
    @(negedge clk);
    checks++;
    if (wr_en !== 1'b0) begin
      bad++;
      $display("FAIL R11: wr_en second cycle actual=%b expected=0", wr_en);
    end

    // R5 R6: attribute plane, col bit5 ignored, data with bit7 set is still data
    push_exp(5'd7, 5'd5, 1'b1, 9'h0F0, "R5");
    send(8'hA7); send(8'h25); send(8'hF0);
    // R6: same-row column/data pairs
    push_exp(5'd7, 5'd1, 1'b1, 9'h011, "R6");
    push_exp(5'd7, 5'd2, 1'b1, 9'h022, "R6");
    send(8'h01); send(8'h11); send(8'h02); send(8'h22);
    drained("R6");

    // R7 R8 R9: streaming from column 30, bit8 held, wraps to next row
    pulse_frame(1'b0, 8'h00);
    push_exp(5'd2, 5'd30, 1'b0, 9'h101, "R8");
    push_exp(5'd2, 5'd31, 1'b0, 9'h182, "R9");
    push_exp(5'd3, 5'd0,  1'b0, 9'h103, "R7");
    send(8'h82); send(8'h7E); send(8'h01); send(8'h82); send(8'h03);
    drained("R7");

    // R10: stop pulse then low byte ignored
    pulse_frame(1'b0, 8'h00);
    send(8'h04);
    drained("R10");

    // R7: row 31 column 31 wraps to row 0 column 0, back-to-back bytes
    push_exp(5'd31, 5'd31, 1'b0, 9'h0AA, "R7");
    push_exp(5'd0,  5'd0,  1'b0, 9'h0BB, "R7");
    send(8'h9F); send(8'h5F);
    @(negedge clk); byte_vld = 1'b1; byte_in = 8'hAA;
    @(negedge clk); byte_in = 8'hBB;
    @(negedge clk); byte_vld = 1'b0;
    drained("R7");

    // R10: frame in the middle of a packet drops the pending data byte
    pulse_frame(1'b0, 8'h00);
    send(8'h81); send(8'h03);
    pulse_frame(1'b0, 8'h00);
    send(8'h44);
    drained("R10");

    // R12: row byte presented with frame_evt is discarded
    pulse_frame(1'b1, 8'h85);
    send(8'h06); send(8'h07);
    drained("R12");

    // R3: column without stream bit after a streaming transaction -> single write
    push_exp(5'd9, 5'd4, 1'b0, 9'h0C3, "R3");
    send(8'h89); send(8'h04); send(8'hC3); send(8'h12);
    drained("R3");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule